// File: doc/BRIEF.md
# Unlock Command Sequence Decoder for a Byte-Wide Nonvolatile Memory

This block sits on the write side of a parallel, byte-wide nonvolatile memory. Each write cycle presents an address and a data byte together with a one-clock write strobe. The block watches that stream for multi-cycle unlock sequences. When one completes, it raises a one-clock command strobe: protected page write start, protection removal, full-array erase, identification-mode entry or identification-mode exit. It holds two mode flags. The first is a global write-protect flag for the whole array. The second is an identification-mode flag, which makes reads at the bottom two addresses return a fixed maker byte and a device code byte.

Every sequence opens with two key cycles. The byte AAh is written at key address 5555h, then the byte 55h at key address 2AAAh. A third cycle at 5555h either finishes a short command or, with 80h, extends the sequence to six cycles. During command cycles only the low 15 address bits are compared. A write that breaks a sequence returns the sequencer to idle and is treated as an ordinary byte write, provided writes are currently allowed.

When protection is on, ordinary writes are allowed only inside a load window. The window opens with a protected write command and is renewed by each byte accepted inside it. A write outside the window is dropped, and a busy indication is raised for a fixed number of clocks.

Top module: `nvm_unlock_decoder`

## Requirements
- R1: After reset, prot_on, id_mode and busy are 0, every strobe is 0, and id_hit is 0 with id_byte 00h.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, in that order, raise pwrite_stb for one clock after the third write's edge. prot_on reads 1 in that same clock and stays set until an unprotect command.
- R3: The writes AAh@5555h, 55h@2AAAh, 90h@5555h raise id_enter_stb and set id_mode. The same two key writes followed by F0h@5555h raise id_exit_stb and clear id_mode. In both cases the strobe and the flag change take effect in the same clock.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by a final byte at 5555h, act by that final byte. 20h raises unprot_stb and clears prot_on. 10h raises erase_stb. 60h raises id_enter_stb and sets id_mode.
- R5: In command cycles, write address bits 16 and 15 are ignored. Only bits 14 to 0 are compared against 5555h and 2AAAh.
- R6: A write that does not match the step expected by the sequencer returns it to idle. That write is reported by byte_wr_stb, with its full address and data on byte_wr_addr and byte_wr_data one clock later, when it is accepted. Writes absorbed into a sequence are never reported as byte writes.
- R7: A write of AAh@5555h at any step where it is not the expected cycle restarts the sequence, so the next expected cycle is 55h@2AAAh.
- R8: A non-command write is accepted when prot_on is 0 or the load window is open. Otherwise it is dropped, and busy goes high from the next clock for exactly BUSY_CYCLES clocks. A new dropped write restarts that count.
- R9: The load window opens on pwrite_stb and is renewed by each accepted byte write made inside it. A write whose edge falls k clocks after the last opening or renewal is accepted for k up to WIN_CYCLES and dropped for k = WIN_CYCLES+1.
- R10: id_hit is 1 exactly when id_mode is 1 and rd_addr bits 14 to 1 are zero. id_byte is then BFh for rd_addr bit 0 = 0 and DEV_CODE for bit 0 = 1. Otherwise id_byte is 00h. Both are combinational from rd_addr.
- R11: The command strobes pwrite_stb, unprot_stb, erase_stb, id_enter_stb and id_exit_stb are mutually exclusive, and each lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-clock write cycle strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data byte |
| rd_addr | input | ADDR_W | Read address for identification lookup |
| prot_on | output | 1 | Global write-protect flag |
| id_mode | output | 1 | Identification mode flag |
| busy | output | 1 | High while recovering from a dropped protected write |
| pwrite_stb | output | 1 | Protected page write start strobe |
| unprot_stb | output | 1 | Protection removal strobe |
| erase_stb | output | 1 | Full-array erase strobe |
| id_enter_stb | output | 1 | Identification mode entry strobe |
| id_exit_stb | output | 1 | Identification mode exit strobe |
| byte_wr_stb | output | 1 | Accepted ordinary byte write strobe |
| byte_wr_addr | output | ADDR_W | Address of the accepted byte write |
| byte_wr_data | output | 8 | Data of the accepted byte write |
| id_hit | output | 1 | Read address hits an identification byte |
| id_byte | output | 8 | Identification byte for rd_addr |

## Verification
The hardest condition to reach is the edge of the load window. A write landing exactly WIN_CYCLES clocks after the last renewal must be accepted, and one landing a clock later must be dropped and start the busy count. The stimulus reaches this with counted idle gaps after a protected write command. It also covers broken sequences, such as a wrong third byte while protection is on, and restarts from the middle of a six-cycle prefix. A long random phase then mixes the key bytes, opcodes, don't-care high address bits and long gaps. A behavioural model checks every output against this mix on every clock.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

  localparam int KEY_W  = 15;
  localparam int BYTE_W = 8;

  localparam logic [KEY_W-1:0]  KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0]  KEY_ADDR_B = 15'h2AAA;
  localparam logic [BYTE_W-1:0] KEY_BYTE_A = 8'hAA;
  localparam logic [BYTE_W-1:0] KEY_BYTE_B = 8'h55;

  localparam logic [BYTE_W-1:0] OP_PWRITE  = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_ID_IN   = 8'h90;
  localparam logic [BYTE_W-1:0] OP_ID_OUT  = 8'hF0;
  localparam logic [BYTE_W-1:0] OP_EXTEND  = 8'h80;
  localparam logic [BYTE_W-1:0] OP_UNPROT  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_ERASE   = 8'h10;
  localparam logic [BYTE_W-1:0] OP_ID_ALT  = 8'h60;
  localparam logic [BYTE_W-1:0] ID_MAKER   = 8'hBF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_EXT0,
    ST_EXT1,
    ST_EXT2
  } seq_state_t;

  typedef struct packed {
    logic pwrite;
    logic unprot;
    logic erase;
    logic id_in;
    logic id_out;
    logic stray;
  } seq_ev_t;

  function automatic logic bus_match(input logic [KEY_W-1:0] a,
                                     input logic [BYTE_W-1:0] d,
                                     input logic [KEY_W-1:0] ea,
                                     input logic [BYTE_W-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic id_window(input logic [KEY_W-1:0] a);
    return a[KEY_W-1:1] == '0;
  endfunction

  function automatic logic [BYTE_W-1:0] id_select(input logic lsb,
                                                  input logic [BYTE_W-1:0] dev);
    return lsb ? dev : ID_MAKER;
  endfunction

endpackage

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
  import nvm_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output seq_ev_t           ev
);

  seq_state_t state_q, state_d;
  logic is_first, is_second, at_cmd;

  assign is_first  = bus_match(key_addr, wr_data, KEY_ADDR_A, KEY_BYTE_A);
  assign is_second = bus_match(key_addr, wr_data, KEY_ADDR_B, KEY_BYTE_B);
  assign at_cmd    = key_addr == KEY_ADDR_A;

  always_comb begin
    state_d = state_q;
    ev      = '0;
    if (wr_en) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_first) state_d = ST_KEY1;
          else          ev.stray = 1'b1;
        end
        ST_KEY1: begin
          if (is_second)     state_d = ST_KEY2;
          else if (is_first) state_d = ST_KEY1;
          else begin
            state_d  = ST_IDLE;
            ev.stray = 1'b1;
          end
        end
        ST_KEY2: begin
          state_d = ST_IDLE;
          if (at_cmd && wr_data == OP_PWRITE)      ev.pwrite = 1'b1;
          else if (at_cmd && wr_data == OP_ID_IN)  ev.id_in  = 1'b1;
          else if (at_cmd && wr_data == OP_ID_OUT) ev.id_out = 1'b1;
          else if (at_cmd && wr_data == OP_EXTEND) state_d   = ST_EXT0;
          else if (is_first)                       state_d   = ST_KEY1;
          else                                     ev.stray  = 1'b1;
        end
        ST_EXT0: begin
          if (is_first) state_d = ST_EXT1;
          else begin
            state_d  = ST_IDLE;
            ev.stray = 1'b1;
          end
        end
        ST_EXT1: begin
          if (is_second)     state_d = ST_EXT2;
          else if (is_first) state_d = ST_KEY1;
          else begin
            state_d  = ST_IDLE;
            ev.stray = 1'b1;
          end
        end
        ST_EXT2: begin
          state_d = ST_IDLE;
          if (at_cmd && wr_data == OP_UNPROT)      ev.unprot = 1'b1;
          else if (at_cmd && wr_data == OP_ERASE)  ev.erase  = 1'b1;
          else if (at_cmd && wr_data == OP_ID_ALT) ev.id_in  = 1'b1;
          else if (is_first)                       state_d   = ST_KEY1;
          else                                     ev.stray  = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/nvm_hold_timer.sv
module nvm_hold_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);

  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= LEN_V;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = cnt_q != '0;

endmodule

// File: rtl/nvm_mode_ctrl.sv
module nvm_mode_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int BUSY_CYCLES = 60000,
  parameter int WIN_CYCLES  = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ev_t           ev,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              prot_on,
  output logic              id_mode,
  output logic              busy,
  output logic              win_open,
  output logic              pwrite_stb,
  output logic              unprot_stb,
  output logic              erase_stb,
  output logic              id_enter_stb,
  output logic              id_exit_stb,
  output logic              byte_wr_stb,
  output logic [ADDR_W-1:0] byte_wr_addr,
  output logic [BYTE_W-1:0] byte_wr_data
);

  logic accept, blocked, win_load;

  assign accept   = ev.stray && (!prot_on || win_open);
  assign blocked  = ev.stray && prot_on && !win_open;
  assign win_load = ev.pwrite || (accept && win_open);

  nvm_hold_timer #(.LEN(WIN_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .active(win_open)
  );

  nvm_hold_timer #(.LEN(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(blocked), .active(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_on      <= 1'b0;
      id_mode      <= 1'b0;
      pwrite_stb   <= 1'b0;
      unprot_stb   <= 1'b0;
      erase_stb    <= 1'b0;
      id_enter_stb <= 1'b0;
      id_exit_stb  <= 1'b0;
      byte_wr_stb  <= 1'b0;
      byte_wr_addr <= '0;
      byte_wr_data <= '0;
    end else begin
      pwrite_stb   <= ev.pwrite;
      unprot_stb   <= ev.unprot;
      erase_stb    <= ev.erase;
      id_enter_stb <= ev.id_in;
      id_exit_stb  <= ev.id_out;
      byte_wr_stb  <= accept;
      if (accept) begin
        byte_wr_addr <= wr_addr;
        byte_wr_data <= wr_data;
      end
      if (ev.pwrite)      prot_on <= 1'b1;
      else if (ev.unprot) prot_on <= 1'b0;
      if (ev.id_in)       id_mode <= 1'b1;
      else if (ev.id_out) id_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/nvm_id_reader.sv
module nvm_id_reader
  import nvm_cmd_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h5E
) (
  input  logic              id_mode,
  input  logic [KEY_W-1:0]  rd_key,
  output logic              id_hit,
  output logic [BYTE_W-1:0] id_byte
);

  assign id_hit  = id_mode && id_window(rd_key);
  assign id_byte = id_hit ? id_select(rd_key[0], DEV_CODE) : '0;

endmodule

// File: rtl/nvm_unlock_decoder.sv
module nvm_unlock_decoder
  import nvm_cmd_pkg::*;
#(
  parameter int         ADDR_W      = 17,
  parameter int         BUSY_CYCLES = 60000,
  parameter int         WIN_CYCLES  = 40000,
  parameter logic [7:0] DEV_CODE    = 8'h5E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_on,
  output logic              id_mode,
  output logic              busy,
  output logic              pwrite_stb,
  output logic              unprot_stb,
  output logic              erase_stb,
  output logic              id_enter_stb,
  output logic              id_exit_stb,
  output logic              byte_wr_stb,
  output logic [ADDR_W-1:0] byte_wr_addr,
  output logic [7:0]        byte_wr_data,
  output logic              id_hit,
  output logic [7:0]        id_byte
);

  seq_ev_t seq_ev;
  logic    win_open;
  logic    unused_rd_hi;

  nvm_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .key_addr(wr_addr[KEY_W-1:0]), .wr_data(wr_data), .ev(seq_ev)
  );

  nvm_mode_ctrl #(
    .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES), .WIN_CYCLES(WIN_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev(seq_ev),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .prot_on(prot_on), .id_mode(id_mode), .busy(busy), .win_open(win_open),
    .pwrite_stb(pwrite_stb), .unprot_stb(unprot_stb), .erase_stb(erase_stb),
    .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
    .byte_wr_stb(byte_wr_stb), .byte_wr_addr(byte_wr_addr),
    .byte_wr_data(byte_wr_data)
  );

  nvm_id_reader #(.DEV_CODE(DEV_CODE)) u_id (
    .id_mode(id_mode), .rd_key(rd_addr[KEY_W-1:0]),
    .id_hit(id_hit), .id_byte(id_byte)
  );

  assign unused_rd_hi = ^rd_addr[ADDR_W-1:KEY_W];

endmodule

// File: rtl/nvm_unlock_decoder_chk.sv
module nvm_unlock_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic prot_on,
  input logic id_mode,
  input logic busy,
  input logic win_open,
  input logic pwrite_stb,
  input logic unprot_stb,
  input logic erase_stb,
  input logic id_enter_stb,
  input logic id_exit_stb,
  input logic byte_wr_stb,
  input logic id_hit
);

  logic [4:0] cmd_stb;
  assign cmd_stb = {pwrite_stb, unprot_stb, erase_stb, id_enter_stb, id_exit_stb};

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb));

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb != '0) |=> (cmd_stb == '0));

  p_pwrite_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwrite_stb |-> prot_on);

  p_prot_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> pwrite_stb);

  p_unprot_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unprot_stb |-> !prot_on);

  p_prot_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> unprot_stb);

  p_id_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter_stb |-> id_mode);

  p_id_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit_stb |-> !id_mode);

  p_write_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr_stb || cmd_stb != '0) |-> $past(wr_en));

  p_blocked_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr_stb |-> (!$past(prot_on) || $past(win_open)));

  p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && prot_on && !win_open));

  p_id_hit_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_hit |-> id_mode);

endmodule

bind nvm_unlock_decoder nvm_unlock_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .prot_on(prot_on),
  .id_mode(id_mode), .busy(busy), .win_open(win_open),
  .pwrite_stb(pwrite_stb), .unprot_stb(unprot_stb), .erase_stb(erase_stb),
  .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
  .byte_wr_stb(byte_wr_stb), .id_hit(id_hit)
);

// File: tb/nvm_unlock_decoder_tb.sv
`timescale 1ns/1ps
module nvm_unlock_decoder_tb;

  localparam int AW   = 17;
  localparam int BUSY = 24;
  localparam int WIN  = 16;
  localparam logic [7:0] DEV = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic prot_on, id_mode, busy, pwrite_stb, unprot_stb, erase_stb;
  logic id_enter_stb, id_exit_stb, byte_wr_stb, id_hit;
  logic [AW-1:0] byte_wr_addr;
  logic [7:0] byte_wr_data, id_byte;

  always #2.5 clk = ~clk;

  nvm_unlock_decoder #(
    .ADDR_W(AW), .BUSY_CYCLES(BUSY), .WIN_CYCLES(WIN), .DEV_CODE(DEV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .prot_on(prot_on),
    .id_mode(id_mode), .busy(busy), .pwrite_stb(pwrite_stb),
    .unprot_stb(unprot_stb), .erase_stb(erase_stb),
    .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
    .byte_wr_stb(byte_wr_stb), .byte_wr_addr(byte_wr_addr),
    .byte_wr_data(byte_wr_data), .id_hit(id_hit), .id_byte(id_byte)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int m_step, m_busy, m_win;
  bit m_prot, m_id;
  bit e_pw, e_un, e_er, e_in, e_out, e_bw;
  int e_waddr, e_wdata;
  int mk, md, ow;
  bit mp, stray, aa, k55, at;

  always @(posedge clk) begin
    e_pw = 0; e_un = 0; e_er = 0; e_in = 0; e_out = 0; e_bw = 0;
    if (!rst_n) begin
      m_step = 0; m_busy = 0; m_win = 0; m_prot = 0; m_id = 0;
      e_waddr = 0; e_wdata = 0;
    end else begin
      ow = m_win; mp = m_prot;
      if (m_busy > 0) m_busy--;
      if (m_win > 0) m_win--;
      if (wr_en) begin
        mk = int'(wr_addr) % 32768;
        md = int'(wr_data);
        aa  = (mk == 'h5555) && (md == 'hAA);
        k55 = (mk == 'h2AAA) && (md == 'h55);
        at  = (mk == 'h5555);
        stray = 0;
        case (m_step)
          0: if (aa) m_step = 1; else stray = 1;
          1: if (k55) m_step = 2; else if (aa) m_step = 1; else stray = 1;
          2: begin
            m_step = 0;
            if (at && md == 'hA0) e_pw = 1;
            else if (at && md == 'h90) e_in = 1;
            else if (at && md == 'hF0) e_out = 1;
            else if (at && md == 'h80) m_step = 3;
            else if (aa) m_step = 1;
            else stray = 1;
          end
          3: if (aa) m_step = 4; else stray = 1;
          4: if (k55) m_step = 5; else if (aa) m_step = 1; else stray = 1;
          default: begin
            m_step = 0;
            if (at && md == 'h20) e_un = 1;
            else if (at && md == 'h10) e_er = 1;
            else if (at && md == 'h60) e_in = 1;
            else if (aa) m_step = 1;
            else stray = 1;
          end
        endcase
        if (stray) begin
          m_step = 0;
          if (!mp || ow > 0) begin
            e_bw = 1; e_waddr = int'(wr_addr); e_wdata = md;
            if (ow > 0) m_win = WIN;
          end else begin
            m_busy = BUSY;
          end
        end
        if (e_pw) begin m_prot = 1; m_win = WIN; end
        if (e_un) m_prot = 0;
        if (e_in) m_id = 1;
        if (e_out) m_id = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      bit hit;
      hit = m_id && ((int'(rd_addr) % 32768) / 2 == 0);
      chk("R2 pwrite_stb", pwrite_stb, e_pw);
      chk("R2 prot_on", prot_on, m_prot);
      chk("R3 id_mode", id_mode, m_id);
      chk("R3 id_exit_stb", id_exit_stb, e_out);
      chk("R4 id_enter_stb", id_enter_stb, e_in);
      chk("R4 unprot_stb", unprot_stb, e_un);
      chk("R4 erase_stb", erase_stb, e_er);
      chk("R6 byte_wr_stb", byte_wr_stb, e_bw);
      if (e_bw) begin
        chk("R6 byte_wr_addr", byte_wr_addr, e_waddr);
        chk("R6 byte_wr_data", byte_wr_data, e_wdata);
      end
      chk("R8 busy", busy, m_busy > 0);
      chk("R10 id_hit", id_hit, hit);
      chk("R10 id_byte", id_byte, hit ? (rd_addr[0] ? DEV : 8'hBF) : 8'h00);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    #1; wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    #1; wr_en = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic setrd(input logic [AW-1:0] a);
    #1; wr_en = 0; rd_addr = a;
    @(negedge clk);
  endtask

  task automatic cmd3(input logic [7:0] op);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, op);
  endtask

  task automatic cmd6(input logic [7:0] op);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, op);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    run_cmp = 1;

    // R1 reset state
    chk("R1 prot_on", prot_on, 0);
    chk("R1 id_mode", id_mode, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {pwrite_stb, unprot_stb, erase_stb, id_enter_stb, id_exit_stb, byte_wr_stb}, 0);
    chk("R1 id_hit", id_hit, 0);
    chk("R1 id_byte", id_byte, 0);

    // R6 plain write while unprotected
    wr(17'h01234, 8'h5A);
    chk("R6 plain stb", byte_wr_stb, 1);
    chk("R6 plain addr", byte_wr_addr, 17'h01234);
    chk("R6 plain data", byte_wr_data, 8'h5A);
    // R6 key cycles absorbed, breaking cycle written
    wr(17'h05555, 8'hAA);
    chk("R6 key1 absorbed", byte_wr_stb, 0);
    wr(17'h02AAA, 8'h55);
    chk("R6 key2 absorbed", byte_wr_stb, 0);
    wr(17'h00100, 8'h33);
    chk("R6 breaker stb", byte_wr_stb, 1);
    chk("R6 breaker data", byte_wr_data, 8'h33);

    // R3 identification entry and reads (R10)
    cmd3(8'h90);
    chk("R3 enter stb", id_enter_stb, 1);
    chk("R3 enter flag", id_mode, 1);
    idle(1);
    chk("R11 enter stb one clock", id_enter_stb, 0);
    setrd(17'h00000);
    chk("R10 maker hit", id_hit, 1);
    chk("R10 maker byte", id_byte, 8'hBF);
    setrd(17'h18001);
    chk("R10 device byte", id_byte, DEV);
    setrd(17'h00002);
    chk("R10 miss hit", id_hit, 0);
    chk("R10 miss byte", id_byte, 0);
    setrd(17'h00001);
    cmd3(8'hF0);
    chk("R3 exit stb", id_exit_stb, 1);
    chk("R3 exit flag", id_mode, 0);
    chk("R10 off after exit", id_hit, 0);

    // R4 six-cycle alternate entry and erase
    cmd6(8'h60);
    chk("R4 alt entry stb", id_enter_stb, 1);
    chk("R4 alt entry flag", id_mode, 1);
    cmd3(8'hF0);
    cmd6(8'h10);
    chk("R4 erase stb", erase_stb, 1);
    chk("R4 erase keeps prot", prot_on, 0);
    idle(1);
    chk("R11 erase one clock", erase_stb, 0);

    // R2 / R5 protected write with high address bits set
    wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h15555, 8'hA0);
    chk("R5 high bits ignored", pwrite_stb, 1);
    chk("R2 prot set", prot_on, 1);

    // R9 load window boundary
    wr(17'h00200, 8'h11);
    chk("R9 in window", byte_wr_stb, 1);
    idle(WIN - 1);
    wr(17'h00201, 8'h22);
    chk("R9 last window clock", byte_wr_stb, 1);
    idle(WIN);
    wr(17'h00202, 8'h33);
    chk("R9 after window dropped", byte_wr_stb, 0);
    chk("R8 busy raised", busy, 1);
    idle(BUSY - 1);
    chk("R8 busy held", busy, 1);
    idle(1);
    chk("R8 busy ends", busy, 0);

    // R7 repeated first key restarts at step two
    wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    chk("R7 restart pwrite", pwrite_stb, 1);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    chk("R7 restart mid six", id_enter_stb, 1);
    cmd3(8'hF0);
    idle(WIN + 2);

    // R8 broken sequence while protected, window closed
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h77);
    chk("R8 broken dropped", byte_wr_stb, 0);
    chk("R8 broken busy", busy, 1);
    idle(BUSY + 1);

    // R4 remove protection
    cmd6(8'h20);
    chk("R4 unprot stb", unprot_stb, 1);
    chk("R4 unprot flag", prot_on, 0);
    wr(17'h00300, 8'h44);
    chk("R6 write after unprot", byte_wr_stb, 1);

    // R6 broken six-cycle prefix returns to idle
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h00000, 8'h12);
    chk("R6 six broken written", byte_wr_stb, 1);
    chk("R6 six broken data", byte_wr_data, 8'h12);
    wr(17'h02AAA, 8'h55);
    chk("R6 idle after break", byte_wr_stb, 1);
    idle(2);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [1:0] hi;
      r = $urandom_range(0, 15);
      hi = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 59) == 0) idle(WIN + $urandom_range(0, 10));
      #1;
      rd_addr = {2'($urandom_range(0, 3)), 13'd0, 2'($urandom_range(0, 3))};
      wr_en = 1;
      if (r < 4) begin wr_addr = {hi, 15'h5555}; wr_data = 8'hAA; end
      else if (r < 7) begin wr_addr = {hi, 15'h2AAA}; wr_data = 8'h55; end
      else if (r < 11) begin
        logic [7:0] ops [7];
        ops = '{8'hA0, 8'h90, 8'hF0, 8'h80, 8'h20, 8'h10, 8'h60};
        wr_addr = {hi, 15'h5555}; wr_data = ops[$urandom_range(0, 6)];
      end
      else if (r < 13) begin
        wr_addr = 17'($urandom_range(0, 131071)); wr_data = 8'($urandom_range(0, 255));
      end
      else wr_en = 0;
      @(negedge clk);
    end
    idle(2);

    done = 1;
    summary();
    $finish;
  end

endmodule